// File: doc/BRIEF.md
# Bit-Serial Command and Configuration Port

This block is the slave end of a three-wire serial link (clock, data in, open-drain data out) through which a host microcontroller controls a reader front end. The host opens every transaction with a start condition: the data line rises while the serial clock is high. It then clocks command bits in, most significant first, with each bit sampled on a rising serial clock. Two short three-bit opcodes switch the block at once into a read mode or a write mode. All other commands are full bytes. They load a 6-bit sampling time, store one of four 4-bit configuration pages, set a 4-bit write pulse width (which also enters write mode), or ask for an 8-bit response that the block then shifts out on the next eight serial clocks.

Both serial inputs pass through a synchronizer into the system clock domain, and all edge detection works on the synchronized copies. The data output is an open-drain pull-down enable. When released, the line idles high. In read mode the line follows the demodulated bit input. Every serial bit arrives at a rate the host sets, so the link has no valid/ready handshake and no back-pressure. The host must hold each clock phase for at least four system clock cycles so that the synchronizer sees every level.

Top module: `sercfg_port`

## Requirements
- R1: A rise of the data input while the serial clock is high starts a new frame. It discards any partly received command, cuts off any response in progress, and leaves read or write mode.
- R2: Command bits are taken on rising serial clock edges, most significant bit first. Bits that arrive outside a frame are ignored.
- R3: When the first three bits of a frame are 1,1,1, read mode is entered. When they are 1,1,0, write mode is entered and the pulse width is left unchanged. Each entry raises its one-cycle strobe (`rd_enter_o` or `wr_enter_o`) in the same cycle that the mode output goes high.
- R4: In read mode the output pulls low exactly when `demod_bit_i` is 0. The configuration does not change. Read mode ends on the next rising serial clock.
- R5: The byte 0001NNNN stores N as the pulse width and enters write mode. Write mode ends on the next rising serial clock. The output stays released during write mode. The pulse width changes only in a cycle that raises `wr_enter_o`.
- R6: The byte 10DDDDDD stores D as the sampling time. The byte 00000010 answers with {2'b00, sampling time}.
- R7: The byte 00001000 answers with {2'b00, phase_i}, with `phase_i` taken as the eighth command bit is received.
- R8: The byte 01PPDDDD stores D into page PP. The byte 000001PP answers with the stored page in bits 3:0. For pages 0 and 1, bits 7:4 hold the pulse width. For pages 2 and 3, bits 7:4 hold {0, 0, amp_cmp_i, ant_fail_i}.
- R9: After reset, page 0 is 4'b1000, pages 1 to 3 are 0, the sampling time and pulse width are 0, no mode is active, and the output is released.
- R10: A response is shifted out most significant bit first, one bit per rising serial clock, with a 0 bit driven as a pull-down. After the eighth bit's clock falls, the output is released and stays high.
- R11: `pwr_down_en_o` is page 1 bit 2, `pwr_down_full_o` is page 1 bit 3, and `clk_sel_o` is page 3 bits 1:0. `cfg_pages_o` is {page3, page2, page1, page0}.
- R12: A full byte that matches no command changes no register, produces no response and enters no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial data from the host (asynchronous) |
| phase_i | input | 6 | Measured antenna phase |
| demod_bit_i | input | 1 | Demodulated receive bit, forwarded in read mode |
| amp_cmp_i | input | 1 | Amplitude comparison status flag |
| ant_fail_i | input | 1 | Antenna failure status flag |
| sdo_pull_low_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| rd_mode_o | output | 1 | Read mode active |
| wr_mode_o | output | 1 | Write mode active |
| rd_enter_o | output | 1 | One-cycle strobe on read mode entry |
| wr_enter_o | output | 1 | One-cycle strobe on write mode entry |
| pulse_n_o | output | 4 | Current write pulse width N |
| samp_time_o | output | 6 | Current sampling time |
| cfg_pages_o | output | 16 | All four configuration pages |
| pwr_down_en_o | output | 1 | Power-down enable field |
| pwr_down_full_o | output | 1 | Full power-down (1) or idle (0) select |
| clk_sel_o | output | 2 | Input clock selection field |

## Verification
The bench starts frames in the middle of a command and in the middle of a response, and then checks that the aborted page write left nothing behind and that the next command still decodes. A design that does not reset its bit counter on the start condition would misalign every later byte. It drives the 1,1,0 short opcode after setting N through a full write command. A design that reloads N on the short form would lose the width that had been set. It reads pages 0 and 1 against pages 2 and 3 with the status flags set differently, which catches a design that swaps the upper nibble source. It sends unknown bytes and the maximum 6-bit values to catch loose decoding and truncated fields.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int CMD_W     = 8;
  localparam int NIB_W     = 4;
  localparam int VAL_W     = 6;
  localparam int NUM_PAGES = 4;
  localparam int PG_IDX_W  = $clog2(NUM_PAGES);
  localparam int ARG_W     = CMD_W - 2;
  localparam logic [3:0] PAGE0_RST = 4'b1000;

  typedef enum logic [2:0] {
    FS_IDLE, FS_CMD, FS_RESP, FS_READ, FS_WRITE
  } frame_st_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PULSE_N, OP_PHASE_RD, OP_SAMP_WR, OP_SAMP_RD, OP_PAGE_WR, OP_PAGE_RD
  } op_e;

  function automatic op_e decode_byte(input logic [7:0] b);
    if (b[7:6] == 2'b10)      return OP_SAMP_WR;
    if (b[7:6] == 2'b01)      return OP_PAGE_WR;
    if (b[7:4] == 4'b0001)    return OP_PULSE_N;
    if (b == 8'h08)           return OP_PHASE_RD;
    if (b == 8'h02)           return OP_SAMP_RD;
    if (b[7:2] == 6'b000001)  return OP_PAGE_RD;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_raw,
  input  logic sdi_raw,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_lvl,
  output logic frame_start
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] sdi_pipe;
  logic              sck_prev;
  logic              sdi_prev;
  logic              sck_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      sdi_pipe <= '0;
      sck_prev <= 1'b0;
      sdi_prev <= 1'b0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-2:0], sck_raw};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_raw};
      sck_prev <= sck_pipe[STAGES-1];
      sdi_prev <= sdi_pipe[STAGES-1];
    end
  end

  assign sck_lvl     = sck_pipe[STAGES-1];
  assign sdi_lvl     = sdi_pipe[STAGES-1];
  assign sck_rise    = sck_lvl & ~sck_prev;
  assign sck_fall    = ~sck_lvl & sck_prev;
  // start: data rises while the clock has been high for at least a cycle
  assign frame_start = sdi_lvl & ~sdi_prev & sck_lvl & sck_prev;
endmodule

// File: rtl/sercfg_frame.sv
module sercfg_frame
  import sercfg_pkg::*;
#(
  parameter int CMD_LEN   = CMD_W,
  parameter int SHORT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sdi_lvl,
  input  logic               frame_start,
  input  logic [CMD_LEN-1:0] resp_byte,
  output logic               cmd_go,
  output op_e                cmd_op,
  output logic [ARG_W-1:0]   cmd_arg,
  output logic               rd_mode,
  output logic               wr_mode,
  output logic               rd_stb,
  output logic               wr_stb,
  output logic               out_active,
  output logic               out_bit
);
  localparam int CNT_W  = $clog2(CMD_LEN);
  localparam int OCNT_W = $clog2(CMD_LEN + 1);

  frame_st_e          st;
  logic [CMD_LEN-2:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CMD_LEN-1:0] oreg;
  logic [OCNT_W-1:0]  ocnt;
  logic [CMD_LEN-1:0] next_byte;
  logic               short_hit;
  logic               in_cmd_bit;

  assign next_byte  = {shreg, sdi_lvl};
  assign in_cmd_bit = (st == FS_CMD) && sck_rise && !frame_start;
  assign short_hit  = in_cmd_bit && (bit_cnt == CNT_W'(SHORT_LEN - 1));
  assign cmd_go     = in_cmd_bit && (bit_cnt == CNT_W'(CMD_LEN - 1));
  assign cmd_op     = decode_byte(next_byte);
  assign cmd_arg    = next_byte[ARG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FS_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      oreg    <= '0;
      ocnt    <= '0;
      out_bit <= 1'b1;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
    end else begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      if (frame_start) begin
        st      <= FS_CMD;
        shreg   <= '0;
        bit_cnt <= '0;
        out_bit <= 1'b1;
      end else begin
        unique case (st)
          FS_CMD: begin
            if (sck_rise) begin
              shreg   <= next_byte[CMD_LEN-2:0];
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (short_hit && next_byte[2:0] == 3'b111) begin
                st     <= FS_READ;
                rd_stb <= 1'b1;
              end else if (short_hit && next_byte[2:0] == 3'b110) begin
                st     <= FS_WRITE;
                wr_stb <= 1'b1;
              end else if (cmd_go) begin
                unique case (cmd_op)
                  OP_PULSE_N: begin
                    st     <= FS_WRITE;
                    wr_stb <= 1'b1;
                  end
                  OP_PHASE_RD, OP_SAMP_RD, OP_PAGE_RD: begin
                    st   <= FS_RESP;
                    oreg <= resp_byte;
                    ocnt <= '0;
                  end
                  default: st <= FS_IDLE;
                endcase
              end
            end
          end
          FS_RESP: begin
            if (sck_rise && ocnt != OCNT_W'(CMD_LEN)) begin
              out_bit <= oreg[CMD_LEN-1];
              oreg    <= {oreg[CMD_LEN-2:0], 1'b0};
              ocnt    <= ocnt + OCNT_W'(1);
            end else if (sck_fall && ocnt == OCNT_W'(CMD_LEN)) begin
              st      <= FS_IDLE;
              out_bit <= 1'b1;
            end
          end
          FS_READ, FS_WRITE: begin
            if (sck_rise) st <= FS_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_mode    = (st == FS_READ);
  assign wr_mode    = (st == FS_WRITE);
  assign out_active = (st == FS_RESP);
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int PG_W   = NIB_W,
  parameter int V_W    = VAL_W,
  parameter int PAGES  = NUM_PAGES,
  parameter int RESP_W = CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_go,
  input  op_e                cmd_op,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic [V_W-1:0]     phase_val,
  input  logic               amp_flag,
  input  logic               ant_flag,
  output logic [RESP_W-1:0]  resp_byte,
  output logic [PAGES*PG_W-1:0] pages_flat,
  output logic [V_W-1:0]     samp_q,
  output logic [PG_W-1:0]    pulse_q
);
  localparam int IDX_W = $clog2(PAGES);

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [PG_W-1:0]  hi_nib;

  assign wr_idx = cmd_arg[PG_W +: IDX_W];
  assign rd_idx = cmd_arg[IDX_W-1:0];

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    localparam logic [PG_W-1:0] RST = (g == 0) ? PG_W'(PAGE0_RST) : '0;
    logic [PG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else if (cmd_go && cmd_op == OP_PAGE_WR && wr_idx == IDX_W'(g))
        q <= cmd_arg[PG_W-1:0];
    end
    assign pages_flat[g*PG_W +: PG_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      pulse_q <= '0;
    end else if (cmd_go) begin
      if (cmd_op == OP_SAMP_WR) samp_q  <= cmd_arg[V_W-1:0];
      if (cmd_op == OP_PULSE_N) pulse_q <= cmd_arg[PG_W-1:0];
    end
  end

  // upper nibble: pulse width for the lower half of the pages, status otherwise
  assign hi_nib = rd_idx[IDX_W-1] ? {{(PG_W-2){1'b0}}, amp_flag, ant_flag} : pulse_q;

  always_comb begin
    unique case (cmd_op)
      OP_PHASE_RD: resp_byte = {{(RESP_W-V_W){1'b0}}, phase_val};
      OP_SAMP_RD:  resp_byte = {{(RESP_W-V_W){1'b0}}, samp_q};
      OP_PAGE_RD:  resp_byte = {hi_nib, pages_flat[int'(rd_idx)*PG_W +: PG_W]};
      default:     resp_byte = '0;
    endcase
  end
endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PG_W        = NIB_W,
  parameter int V_W         = VAL_W,
  parameter int PAGES       = NUM_PAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  input  logic [V_W-1:0]        phase_i,
  input  logic                  demod_bit_i,
  input  logic                  amp_cmp_i,
  input  logic                  ant_fail_i,
  output logic                  sdo_pull_low_o,
  output logic                  rd_mode_o,
  output logic                  wr_mode_o,
  output logic                  rd_enter_o,
  output logic                  wr_enter_o,
  output logic [PG_W-1:0]       pulse_n_o,
  output logic [V_W-1:0]        samp_time_o,
  output logic [PAGES*PG_W-1:0] cfg_pages_o,
  output logic                  pwr_down_en_o,
  output logic                  pwr_down_full_o,
  output logic [1:0]            clk_sel_o
);
  localparam int PD_PAGE  = 1;
  localparam int PD_EN_B  = 2;
  localparam int PD_SEL_B = 3;
  localparam int CK_PAGE  = 3;

  logic             sck_rise, sck_fall, sdi_lvl, frame_start;
  logic             cmd_go, out_active, out_bit;
  op_e              cmd_op;
  logic [ARG_W-1:0] cmd_arg;
  logic [CMD_W-1:0] resp_byte;

  sercfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_raw(sck_i), .sdi_raw(sdi_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_lvl(sdi_lvl),
    .frame_start(frame_start)
  );

  sercfg_frame #(.CMD_LEN(CMD_W), .SHORT_LEN(3)) i_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi_lvl(sdi_lvl), .frame_start(frame_start), .resp_byte(resp_byte),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rd_mode(rd_mode_o), .wr_mode(wr_mode_o), .rd_stb(rd_enter_o),
    .wr_stb(wr_enter_o), .out_active(out_active), .out_bit(out_bit)
  );

  sercfg_regs #(.PG_W(PG_W), .V_W(V_W), .PAGES(PAGES), .RESP_W(CMD_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .phase_val(phase_i), .amp_flag(amp_cmp_i), .ant_flag(ant_fail_i),
    .resp_byte(resp_byte), .pages_flat(cfg_pages_o), .samp_q(samp_time_o),
    .pulse_q(pulse_n_o)
  );

  assign sdo_pull_low_o  = (out_active & ~out_bit) | (rd_mode_o & ~demod_bit_i);
  assign pwr_down_en_o   = cfg_pages_o[PD_PAGE*PG_W + PD_EN_B];
  assign pwr_down_full_o = cfg_pages_o[PD_PAGE*PG_W + PD_SEL_B];
  assign clk_sel_o       = cfg_pages_o[CK_PAGE*PG_W +: 2];
endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk #(
  parameter int PG_W = 4,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_mode_o,
  input logic             wr_mode_o,
  input logic             rd_enter_o,
  input logic             wr_enter_o,
  input logic             sdo_pull_low_o,
  input logic [PG_W-1:0]  pulse_n_o,
  input logic [CFG_W-1:0] cfg_pages_o
);
  a_r1_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_mode_o && wr_mode_o));

  a_r3_rd_strobe_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rd_enter_o |-> rd_mode_o);

  a_r3_rd_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_mode_o) |-> rd_enter_o);

  a_r3_wr_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_mode_o) |-> wr_enter_o);

  a_r5_wr_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode_o |-> !sdo_pull_low_o);

  a_r5_pulse_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_n_o) |-> wr_enter_o);

  a_r4_cfg_held_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode_o |=> $stable(cfg_pages_o));
endmodule

bind sercfg_port sercfg_port_chk #(.PG_W(4), .CFG_W(16)) i_chk (.*);

// File: tb/test_sercfg_port.sv
module test_sercfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, sdi = 1'b0;
  logic [5:0] phase = '0;
  logic       demod = 1'b1, amp = 1'b0, ant = 1'b0;
  logic       pull_low, rd_mode, wr_mode, rd_enter, wr_enter;
  logic [3:0] pulse_n;
  logic [5:0] samp;
  logic [15:0] pages;
  logic       pd_en, pd_full;
  logic [1:0] clk_sel;
  logic       sdo_line;

  int checks = 0, fails = 0, rd_strobes = 0, wr_strobes = 0;
  bit settled = 0, finished = 0;
  logic [3:0] exp_pg [4];
  logic [5:0] exp_samp;
  logic [3:0] exp_n;
  bit exp_rd, exp_wr;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdo_line = ~pull_low;

  sercfg_port i_sercfg_port (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .phase_i(phase),
    .demod_bit_i(demod), .amp_cmp_i(amp), .ant_fail_i(ant),
    .sdo_pull_low_o(pull_low), .rd_mode_o(rd_mode), .wr_mode_o(wr_mode),
    .rd_enter_o(rd_enter), .wr_enter_o(wr_enter), .pulse_n_o(pulse_n),
    .samp_time_o(samp), .cfg_pages_o(pages), .pwr_down_en_o(pd_en),
    .pwr_down_full_o(pd_full), .clk_sel_o(clk_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every settled clock
  always @(negedge clk) begin
    if (settled && !finished) begin
      chk("R8 model pages", int'(pages), int'({exp_pg[3], exp_pg[2], exp_pg[1], exp_pg[0]}));
      chk("R6 model sampling time", int'(samp), int'(exp_samp));
      chk("R5 model pulse width", int'(pulse_n), int'(exp_n));
      chk("R3 model read mode", int'(rd_mode), int'(exp_rd));
      chk("R3 model write mode", int'(wr_mode), int'(exp_wr));
    end
  end

  always @(posedge clk) begin
    if (rd_enter) rd_strobes++;
    if (wr_enter) wr_strobes++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start();
    settled = 0;
    sck = 1'b0; idle(HALF);
    sdi = 1'b0; idle(HALF);
    sck = 1'b1; idle(HALF);
    sdi = 1'b1; idle(HALF);
    sck = 1'b0; idle(HALF);
    exp_rd = 0; exp_wr = 0;
  endtask

  task automatic send(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = v[i]; idle(HALF);
      sck = 1'b1; idle(HALF);
      sck = 1'b0;
    end
    idle(HALF);
  endtask

  task automatic get_bits(input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; idle(HALF - 1);
      r = {r[6:0], sdo_line};
      idle(1);
      sck = 1'b0; idle(HALF);
    end
  endtask

  task automatic cmd(input logic [7:0] v);
    frame_start();
    send(v, 8);
  endtask

  task automatic end_mode();
    settled = 0;
    sck = 1'b1; idle(HALF);
    sck = 1'b0; idle(HALF);
    exp_rd = 0; exp_wr = 0;
    settled = 1;
  endtask

  initial begin
    logic [7:0] r;
    int rs, ws;
    exp_pg[0] = 4'b1000; exp_pg[1] = '0; exp_pg[2] = '0; exp_pg[3] = '0;
    exp_samp = '0; exp_n = '0; exp_rd = 0; exp_wr = 0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    settled = 1;

    // R9 reset state
    chk("R9 reset pages", int'(pages), 16'h0008);
    chk("R9 reset sampling time", int'(samp), 0);
    chk("R9 reset pulse width", int'(pulse_n), 0);
    chk("R9 reset line released", int'(sdo_line), 1);
    chk("R9 reset modes", int'({rd_mode, wr_mode}), 0);
    chk("R11 reset clock select", int'(clk_sel), 0);

    // R8 / R2: page write then page reads with status in upper nibble
    cmd(8'h65); exp_pg[2] = 4'h5; settled = 1;
    amp = 1'b1; ant = 1'b0;
    cmd(8'h06); settled = 1; get_bits(8, r);
    chk("R8 page2 read with status", int'(r), 8'h25);
    amp = 1'b0; ant = 1'b1;
    cmd(8'h07); settled = 1; get_bits(8, r);
    chk("R8 page3 read with status", int'(r), 8'h10);
    // R10: line released after the eighth bit
    sck = 1'b1; idle(HALF - 1);
    chk("R10 released after response", int'(sdo_line), 1);
    idle(1); sck = 1'b0; idle(HALF);

    // R5 write with pulse width
    ws = wr_strobes;
    cmd(8'h19); exp_n = 4'h9; exp_wr = 1; settled = 1;
    chk("R5 write mode entered", int'(wr_mode), 1);
    chk("R5 one write strobe", wr_strobes - ws, 1);
    chk("R5 line released in write mode", int'(sdo_line), 1);
    end_mode();
    chk("R5 write mode ended by clock", int'(wr_mode), 0);
    cmd(8'h04); settled = 1; get_bits(8, r);
    chk("R8 page0 carries N", int'(r), 8'h98);
    cmd(8'h05); settled = 1; get_bits(8, r);
    chk("R8 page1 carries N", int'(r), 8'h90);

    // R3 short write keeps N
    ws = wr_strobes;
    frame_start(); send(8'hC0, 3); exp_wr = 1; settled = 1;
    chk("R3 short write mode", int'(wr_mode), 1);
    chk("R3 short write N kept", int'(pulse_n), 9);
    chk("R3 short write strobe", wr_strobes - ws, 1);
    end_mode();

    // R3 / R4 short read with pass-through
    rs = rd_strobes;
    frame_start(); send(8'hE0, 3); exp_rd = 1; settled = 1;
    chk("R3 short read mode", int'(rd_mode), 1);
    chk("R3 short read strobe", rd_strobes - rs, 1);
    demod = 1'b0; idle(2);
    chk("R4 read passes low bit", int'(sdo_line), 0);
    demod = 1'b1; idle(2);
    chk("R4 read passes high bit", int'(sdo_line), 1);
    demod = 1'b0; idle(2);
    end_mode();
    chk("R4 read ended by clock rise", int'(rd_mode), 0);
    chk("R4 line released after read", int'(sdo_line), 1);
    demod = 1'b1;

    // R6 sampling time
    cmd(8'hAA); exp_samp = 6'h2A; settled = 1;
    cmd(8'h02); settled = 1; get_bits(8, r);
    chk("R6 sampling time read", int'(r), 8'h2A);
    cmd(8'hBF); exp_samp = 6'h3F; settled = 1;
    cmd(8'h02); settled = 1; get_bits(8, r);
    chk("R6 sampling time max", int'(r), 8'h3F);

    // R7 phase
    phase = 6'h15;
    cmd(8'h08); settled = 1; get_bits(8, r);
    chk("R7 phase read", int'(r), 8'h15);
    phase = 6'h3F;
    cmd(8'h08); settled = 1; get_bits(8, r);
    chk("R7 phase read max", int'(r), 8'h3F);

    // R1 start aborts a partial command
    frame_start(); send(8'h6F, 5);
    cmd(8'h02); settled = 1; get_bits(8, r);
    chk("R1 aborted write left page2", int'(pages[11:8]), 5);
    chk("R1 next command decodes", int'(r), 8'h3F);

    // R1 start aborts a response in progress
    phase = 6'h2A;
    cmd(8'h08); settled = 1; get_bits(3, r);
    chk("R10 first response bits msb first", int'(r), 3'b001);
    amp = 1'b0; ant = 1'b0;
    cmd(8'h06); settled = 1; get_bits(8, r);
    chk("R1 response after abort", int'(r), 8'h05);

    // R11 decoded fields
    cmd(8'h5C); exp_pg[1] = 4'hC; settled = 1;
    cmd(8'h72); exp_pg[3] = 4'h2; settled = 1;
    chk("R11 power-down enable", int'(pd_en), 1);
    chk("R11 power-down full", int'(pd_full), 1);
    chk("R11 clock select", int'(clk_sel), 2);

    // R12 unknown bytes ignored
    cmd(8'h00); settled = 1; get_bits(8, r);
    chk("R12 byte 00 gives no response", int'(r), 8'hFF);
    cmd(8'h03); settled = 1; get_bits(8, r);
    chk("R12 byte 03 gives no response", int'(r), 8'hFF);
    chk("R12 no mode after unknown byte", int'({rd_mode, wr_mode}), 0);

    // R2 bits outside a frame are ignored
    send(8'h7F, 8); settled = 1; idle(4);
    chk("R2 bits outside frame ignored", int'(pages[15:12]), 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule